// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Double-Cycle Deselect

This block is a small single-port synchronous memory. Every control, address and data input is captured on the rising clock edge. Each word is split into byte lanes, and each lane carries eight data bits plus one parity bit. A read that is registered at edge N has its data in the output register after edge N+2. Writes go through their own registered stage. A read issued on the cycle after a write to the same address therefore returns the new data.

An access begins with an active-low address strobe. On that edge the three chip enables are sampled, and they decide whether the device is selected for the cycles that follow. While the device stays selected, cycles without a strobe keep accessing the memory. An active-low advance input steps the two low address bits, and they wrap inside the aligned group of four words. Without the advance input the cycle repeats the same word. A strobe taken while the enables are not at their active levels deselects the device.

When a run of reads ends, the output enable pipeline keeps the outputs on for one extra cycle, and the last read word is held during that cycle. This lets a second device in a depth-expanded bank take over without a dead cycle. The asynchronous output enable then gates the final valid flag and the data without waiting for a clock.

Top module: `sync_sram_dcd`

## Requirements
- R1: A read registered at edge N gives `rvalid`=1 and the read word on `rdata` after edge N+2. After edge N+1 it has not yet reached the outputs.
- R2: With `gw_n`=0, a selected cycle writes every lane (all 9 bits of each lane), whatever the values of `bwe_n` and `bsel_n`.
- R3: With `gw_n`=1 and `bwe_n`=0, a selected cycle writes lane i only where `bsel_n[i]`=0, and leaves the other lanes unchanged. Lane i occupies bits [9i+8:9i] of the data buses, and bit 9i+8 is that lane's parity bit.
- R4: A selected cycle that writes no lane is a read. This covers `gw_n`=1 with `bwe_n`=1, and `gw_n`=1 with `bwe_n`=0 and all `bsel_n` bits high.
- R5: On a strobe edge the device becomes selected only when `ce_n`=0, `ce_hi`=1 and `ce_lo_n`=0. Any other combination deselects it, and no access takes place.
- R6: When `stb_n`=1 the chip-enable pins are ignored: the device keeps the selection made at the last strobe.
- R7: In a selected cycle without a strobe, `adv_n`=0 adds one to address bits [1:0], wrapping modulo 4, and keeps the upper bits. `adv_n`=1 accesses the same word again.
- R8: After the last read of a run, the output pipeline stays on for exactly one more cycle, and `rdata` holds that last read word during it.
- R9: `rvalid` is the output pipeline enable AND `oe_n`=0. It follows `oe_n` with no clock edge in between, and `rdata` is zero whenever `rvalid` is 0.
- R10: A write followed on the next cycle by a read of the same address returns the newly written data.
- R11: Reset is synchronous and active low. Afterwards `rvalid` and `rdata` are 0, and no access happens until a selecting strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stb_n | input | 1 | Address strobe, active low; loads the address and samples the chip enables |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Expansion enable, active high |
| ce_lo_n | input | 1 | Expansion enable, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane-select write enable, active low |
| bsel_n | input | LANES | Per-lane write select, active low |
| wdata | input | LANES*LANE_W | Write data, 9 bits per lane, parity in the top bit of each lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Output valid flag |

## Verification
The bench keeps a cycle-level model of the selection state, the burst offset, the memory contents and a two-stage read pipeline. It updates that model right after each rising edge from the inputs that were driven for that edge. The data of a read registered at edge N is compared after edge N+2. The one-cycle hold that follows a run of reads is compared after the next edge. Both comparisons are made at the falling edge, so all registered outputs have settled. Output-enable changes have no edge to wait for, so those checks are made a fraction of a cycle after `oe_n` changes and before the next rising edge.

// File: rtl/ssd_pkg.sv
// Shared definitions for the pipelined SRAM with double-cycle deselect.
// Assumes a four-word burst group, so the burst offset is two bits wide.
package ssd_pkg;

    // Kind of access registered in a cycle.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Width of the burst offset inside one aligned group.
    localparam int BURST_W = 2;

    // Next burst offset: advance by one (wrapping), or repeat on suspend.
    function automatic logic [BURST_W-1:0] step_offset(
        input logic [BURST_W-1:0] off,
        input logic               adv_n
    );
        return adv_n ? off : off + 1'b1;
    endfunction

endpackage

// File: rtl/ssd_ctrl.sv
// Input stage. On each rising edge it registers the address, the write data,
// the lane write mask and the access type.
// The selection state is loaded only on strobe edges. Burst offsets are
// derived from the last offset and the advance input.
// Assumes ADDR_W > BURST_W.
module ssd_ctrl #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_n,
    input  logic                adv_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                ce_n,
    input  logic                ce_hi,
    input  logic                ce_lo_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [LANES-1:0]    bsel_n,
    input  logic [DATA_W-1:0]   wdata,
    output ssd_pkg::op_e        op_q,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [LANES-1:0]    lanes_q,
    output logic [DATA_W-1:0]   wdata_q
);
    import ssd_pkg::*;

    localparam int HI_W = ADDR_W - BURST_W;

    logic               sel_r;
    logic [HI_W-1:0]    base_r;
    logic [BURST_W-1:0] off_r;

    logic               strobe;
    logic               chip_ok;
    logic               sel_now;
    logic [HI_W-1:0]    base_now;
    logic [BURST_W-1:0] off_now;
    logic [LANES-1:0]   lanes_now;
    op_e                op_now;

    // Decode strobe, chip selection and the address of this cycle.
    always_comb begin
        strobe   = !stb_n;
        chip_ok  = !ce_n && ce_hi && !ce_lo_n;
        sel_now  = strobe ? chip_ok : sel_r;
        base_now = strobe ? addr[ADDR_W-1:BURST_W] : base_r;
        off_now  = strobe ? addr[BURST_W-1:0] : step_offset(off_r, adv_n);
    end

    // Pick the write lanes: global write covers all, else the per-lane selects.
    always_comb begin
        if (!gw_n)
            lanes_now = '1;
        else if (!bwe_n)
            lanes_now = ~bsel_n;
        else
            lanes_now = '0;
    end

    // Classify the cycle: no access, lane write, or read.
    always_comb begin
        if (!sel_now)
            op_now = OP_NONE;
        else if (|lanes_now)
            op_now = OP_WRITE;
        else
            op_now = OP_READ;
    end

    // Register the selection state, the burst position and the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_r   <= 1'b0;
            base_r  <= '0;
            off_r   <= '0;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            lanes_q <= '0;
            wdata_q <= '0;
        end else begin
            sel_r   <= sel_now;
            base_r  <= base_now;
            off_r   <= off_now;
            op_q    <= op_now;
            addr_q  <= {base_now, off_now};
            lanes_q <= lanes_now;
            wdata_q <= wdata;
        end
    end

    // R6: with no strobe, the selection does not move.
    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_n |=> (sel_r == $past(sel_r)));

    // R7: an advance without a strobe steps the offset by one, modulo four.
    assert_adv_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_n && !adv_n) |=> (off_r == $past(off_r) + 2'd1));

    // R2: a selecting strobe with global write registers a write of every lane.
    assert_gw_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_n && !ce_n && ce_hi && !ce_lo_n && !gw_n)
        |=> (op_q == OP_WRITE && (&lanes_q)));

endmodule

// File: rtl/ssd_array.sv
// Storage array, one memory per byte lane.
// Writes take effect on the edge after the access was registered. A read
// registers the addressed word on that same edge, so the word becomes the
// second pipeline stage of a read.
// Assumes one access per cycle, which the input stage guarantees.
module ssd_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ssd_pkg::op_e        op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LANES-1:0]    lanes,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_ok
);
    import ssd_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q_r;

        // Write this lane when selected; capture it on a read.
        always_ff @(posedge clk) begin
            if (op == OP_WRITE && lanes[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (op == OP_READ)
                q_r <= mem[addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = q_r;
    end

    // Flag that the captured word belongs to a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ok <= 1'b0;
        else
            rd_ok <= (op == OP_READ);
    end

    // R1: a registered read always yields a captured word one edge later.
    assert_read_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> rd_ok);

endmodule

// File: rtl/ssd_outq.sv
// Output stage. It holds the output register and the pipelined enable.
// The enable stays on for one extra cycle after a run of reads ends, and the
// output register keeps the last word during that cycle. The asynchronous
// output enable gates the valid flag and the data without a clock.
module ssd_outq #(
    parameter int DATA_W = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_ok,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                oe_n,
    output logic                drive,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);
    logic              en2;
    logic              en3;
    logic [DATA_W-1:0] dout;

    // Load the output register on reads and shift the two enable stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en2  <= 1'b0;
            en3  <= 1'b0;
            dout <= '0;
        end else begin
            en2 <= rd_ok;
            en3 <= en2;
            if (rd_ok)
                dout <= rd_data;
        end
    end

    // Combine the enable stages with the asynchronous output enable.
    always_comb begin
        drive  = en2 || en3;
        rvalid = drive && !oe_n;
        rdata  = rvalid ? dout : '0;
    end

    // R8: the outputs stay on during the cycle in which new read data stops.
    assert_tail_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en2) |-> drive);

    // R8: during the extra cycle the last word is held.
    assert_tail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en3 && !en2) |-> $stable(dout));

endmodule

// File: rtl/sync_sram_dcd.sv
// Top of the pipelined SRAM with double-cycle deselect. It wires the input
// stage, the lane array and the output stage together.
// Read latency is two edges from the registered access to the output.
// Assumes ADDR_W of at least 3, so that a burst group of four words fits.
module sync_sram_dcd #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb_n,
    input  logic                     adv_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     ce_n,
    input  logic                     ce_hi,
    input  logic                     ce_lo_n,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [LANES-1:0]         bsel_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic                     oe_n,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rvalid
);
    import ssd_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] arr_data;
    logic              arr_ok;
    logic              drive;

    ssd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_n   (stb_n),
        .adv_n   (adv_n),
        .addr    (addr),
        .ce_n    (ce_n),
        .ce_hi   (ce_hi),
        .ce_lo_n (ce_lo_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .wdata   (wdata),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .lanes_q (lanes_q),
        .wdata_q (wdata_q)
    );

    ssd_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_q),
        .addr    (addr_q),
        .lanes   (lanes_q),
        .wdata   (wdata_q),
        .rd_data (arr_data),
        .rd_ok   (arr_ok)
    );

    ssd_outq #(.DATA_W(DATA_W)) u_outq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ok   (arr_ok),
        .rd_data (arr_data),
        .oe_n    (oe_n),
        .drive   (drive),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    // R1: a read registered in the input stage turns the outputs on two edges later.
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_READ) |-> ##2 drive);

endmodule

// File: tb/sync_sram_dcd_tb.sv
// Bench for sync_sram_dcd. It mixes directed corner cases with seeded
// random traffic and compares every cycle against a cycle-level model.
module sync_sram_dcd_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int LW    = 9;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          stb_n   = 1'b1;
    logic          adv_n   = 1'b1;
    logic [AW-1:0] addr    = '0;
    logic          ce_n    = 1'b1;
    logic          ce_hi   = 1'b0;
    logic          ce_lo_n = 1'b1;
    logic          gw_n    = 1'b1;
    logic          bwe_n   = 1'b1;
    logic [LN-1:0] bsel_n  = '1;
    logic [DW-1:0] wdata   = '0;
    logic          oe_n    = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_sram_dcd #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .adv_n(adv_n), .addr(addr),
        .ce_n(ce_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    int    vectors = 0;
    int    fails   = 0;
    string tag     = "R11";
    bit    done    = 1'b0;

    // Model state.
    bit            m_sel = 1'b0;
    logic [AW-3:0] m_base = '0;
    logic [1:0]    m_off = '0;
    logic [DW-1:0] m_mem [DEPTH];
    bit            s0r = 1'b0, s1r = 1'b0, en2 = 1'b0, en3 = 1'b0;
    logic [DW-1:0] s0d = '0, s1d = '0, dout = '0;

    // Lanes written by the current controls (R2, R3, R4).
    function automatic logic [LN-1:0] exp_lanes();
        if (!gw_n)  return '1;
        if (!bwe_n) return ~bsel_n;
        return '0;
    endfunction

    // Merge new lane data into an old word.
    function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                            logic [LN-1:0] ln);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < LN; i++)
            if (ln[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    // Expected {rvalid, rdata} from the model and the current oe_n (R9).
    function automatic logic [DW:0] exp_out();
        logic v = (en2 || en3) && !oe_n;
        return {v, v ? dout : {DW{1'b0}}};
    endfunction

    // Advance the model by one rising edge.
    task automatic model_edge();
        logic [AW-1:0] a;
        logic [LN-1:0] ln;
        if (!rst_n) begin
            m_sel = 1'b0; s0r = 1'b0; s1r = 1'b0; en2 = 1'b0; en3 = 1'b0; dout = '0;
        end else begin
            en3 = en2;
            en2 = s1r;
            if (s1r) dout = s1d;
            s1r = s0r;
            s1d = s0d;
            if (!stb_n) begin
                m_sel  = !ce_n && ce_hi && !ce_lo_n;
                m_base = addr[AW-1:2];
                m_off  = addr[1:0];
            end else if (!adv_n) begin
                m_off = m_off + 2'd1;
            end
            a   = {m_base, m_off};
            ln  = exp_lanes();
            s0r = 1'b0;
            if (m_sel) begin
                if (|ln) m_mem[a] = merge(m_mem[a], wdata, ln);
                else begin
                    s0r = 1'b1;
                    s0d = m_mem[a];
                end
            end
        end
    endtask

    task automatic check(string t, logic [DW:0] act, logic [DW:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got valid=%b data=%h expected valid=%b data=%h",
                     t, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
        end
    endtask

    // One clock: edge, model update, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, {rvalid, rdata}, exp_out());
    endtask

    task automatic ce_ok();
        ce_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
    endtask

    task automatic no_write();
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    endtask

    task automatic strobe_wr(logic [AW-1:0] a, logic [DW-1:0] d);
        stb_n = 1'b0; ce_ok(); addr = a; gw_n = 1'b0; wdata = d; adv_n = 1'b1;
        bwe_n = 1'($urandom); bsel_n = 4'($urandom);
        step();
    endtask

    task automatic strobe_rd(logic [AW-1:0] a);
        stb_n = 1'b0; ce_ok(); addr = a; no_write(); adv_n = 1'b1;
        step();
    endtask

    task automatic desel();
        stb_n = 1'b0; ce_n = 1'b1; no_write();
        step();
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {4'($urandom), 32'($urandom)};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));

        // R11: reset state.
        tag = "R11";
        repeat (3) step();
        rst_n = 1'b1;
        desel(); desel();

        // R2: preload every word with global write, ignoring lane controls.
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) strobe_wr(6'(a), rnd_word());
        desel();
        for (int a = 0; a < 4; a++) strobe_rd(6'(a * 9));
        desel(); desel(); desel();

        // R1: latency of a single read.
        tag = "R1";
        strobe_rd(6'd5);
        desel(); desel(); desel(); desel();

        // R3: every lane mask, written then read back.
        tag = "R3";
        for (int m = 0; m < 16; m++) begin
            stb_n = 1'b0; ce_ok(); addr = 6'd9; gw_n = 1'b1; bwe_n = 1'b0;
            bsel_n = 4'(m); wdata = rnd_word();
            step();
            strobe_rd(6'd9);
        end
        desel(); desel(); desel();

        // R4: lane selects without the lane write enable read instead.
        tag = "R4";
        stb_n = 1'b0; ce_ok(); addr = 6'd11; gw_n = 1'b1; bwe_n = 1'b1;
        bsel_n = '0; wdata = '1;
        step();
        strobe_rd(6'd11);
        desel(); desel(); desel();

        // R10: write then read the same word on the next cycle.
        tag = "R10";
        for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] a = 6'($urandom);
            strobe_wr(a, rnd_word());
            strobe_rd(a);
        end
        desel(); desel(); desel();

        // R5: only one enable combination selects on a strobe.
        tag = "R5";
        for (int k = 0; k < 8; k++) begin
            stb_n = 1'b0; {ce_n, ce_hi, ce_lo_n} = 3'(k); addr = 6'd20;
            gw_n = 1'b0; wdata = {4'(k), 32'(k) * 32'h01010101};
            step();
        end
        strobe_rd(6'd20);
        desel(); desel(); desel();

        // R6: enable pins ignored without a strobe.
        tag = "R6";
        strobe_rd(6'd30);
        stb_n = 1'b1; ce_n = 1'b1; ce_hi = 1'b0; ce_lo_n = 1'b1; adv_n = 1'b1;
        step(); step(); step();
        desel();
        stb_n = 1'b1; ce_ok(); gw_n = 1'b0; wdata = '1;
        step(); step();
        strobe_rd(6'd30);
        desel(); desel(); desel();

        // R7: burst advance wraps inside the group; suspend repeats.
        tag = "R7";
        strobe_rd(6'd14);
        stb_n = 1'b1; adv_n = 1'b0;
        repeat (5) step();
        adv_n = 1'b1;
        step(); step();
        stb_n = 1'b0; ce_ok(); addr = 6'd42; gw_n = 1'b0; wdata = rnd_word();
        step();
        stb_n = 1'b1; adv_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            wdata = rnd_word();
            step();
        end
        gw_n = 1'b1;
        strobe_rd(6'd40);
        stb_n = 1'b1; adv_n = 1'b0;
        repeat (4) step();
        desel(); desel(); desel();

        // R8: one extra output cycle after a run of reads, then a gap pattern.
        tag = "R8";
        strobe_rd(6'd1); strobe_rd(6'd2); strobe_rd(6'd3);
        desel(); desel(); desel(); desel(); desel();
        strobe_rd(6'd4); desel(); strobe_rd(6'd6);
        strobe_wr(6'd7, rnd_word());
        desel(); desel(); desel(); desel();

        // R9: the output enable acts without a clock edge.
        tag = "R9";
        strobe_rd(6'd8);
        desel();
        desel();
        #1 oe_n = 1'b1;
        #1 check("R9", {rvalid, rdata}, exp_out());
        oe_n = 1'b0;
        #1 check("R9", {rvalid, rdata}, exp_out());
        desel(); desel();

        // R11: after a mid-run reset, no access until a selecting strobe.
        tag = "R11";
        strobe_rd(6'd12);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        stb_n = 1'b1; ce_ok(); gw_n = 1'b0; adv_n = 1'b0; wdata = '1;
        step(); step();
        strobe_rd(6'd12); strobe_rd(6'd13);
        desel(); desel(); desel();

        // R1: seeded random traffic.
        tag = "R1";
        for (int c = 0; c < 3000; c++) begin
            stb_n  = ($urandom % 2) == 0;
            if (($urandom % 8) != 0) ce_ok();
            else {ce_n, ce_hi, ce_lo_n} = 3'($urandom);
            addr   = 6'($urandom);
            adv_n  = 1'($urandom);
            gw_n   = ($urandom % 5) != 0;
            bwe_n  = 1'($urandom);
            bsel_n = 4'($urandom);
            wdata  = rnd_word();
            oe_n   = ($urandom % 10) == 0;
            step();
        end
        oe_n = 1'b0;
        desel(); desel(); desel();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule